// File: doc/BRIEF.md
# Ternary CAM with Lowest-Index Priority Encoder

This block is a small ternary content-addressable memory. Every entry keeps two words of the same width: a data word and a mask word. Together they give each stored bit one of three effective values: one, zero, or don't-care. A host sends one command per cycle over a single command port. It can write or read either word of an entry by address. It can also present a search key and get back whether any entry matches and which one.

When several entries match, the entry with the lowest address wins. Bit 0 of each data word is an occupancy marker. A LEARN command puts the key into the lowest-addressed empty entry and marks that entry occupied. A full flag is raised once every entry is occupied. Searches only consider occupied entries. The depth is a small parameter (16 by default) and the word width is 68 bits.

Top module: `tcam_core`

## Requirements
- R1: After reset, hit_o=0, hit_idx_o=0, rd_valid_o=0 and full_o=0, and every data and mask word reads as zero.
- R2: The opcode on cmd_op_i is 00 READ, 01 WRITE, 10 SEARCH or 11 LEARN, and it is taken when cmd_valid_i=1. WRITE stores dq_i into entry addr_i, in the data word when cmd_sel_i=0 or in the mask word when cmd_sel_i=1. READ returns the word chosen by cmd_sel_i on rd_data_o one cycle later, with rd_valid_o high for exactly that cycle.
- R3: An entry matches a SEARCH when its data bit 0 is 1 and, for every bit i from 1 upward, either mask bit i is 1 or data bit i equals key bit i. Key bit 0 and mask bit 0 play no part in the match.
- R4: When several entries match, hit_idx_o reports the lowest matching address.
- R5: hit_o and hit_idx_o update one cycle after a SEARCH and hold their values until the next SEARCH. On a miss, hit_o=0 and hit_idx_o=0.
- R6: A LEARN that finds an empty entry (data bit 0 = 0) writes the key into the lowest such entry with bit 0 forced to 1, and clears that entry's mask word.
- R7: full_o is 1 exactly when every entry has data bit 0 = 1. It follows the command that changes occupancy one cycle later.
- R8: A LEARN issued while full_o=1 changes no entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_op_i | input | 2 | Opcode: 00 READ, 01 WRITE, 10 SEARCH, 11 LEARN |
| cmd_sel_i | input | 1 | READ/WRITE word select: 0 data, 1 mask |
| addr_i | input | 4 | Entry address for READ/WRITE |
| dq_i | input | 68 | Write word or search/learn key |
| rd_valid_o | output | 1 | Read data valid, one-cycle pulse |
| rd_data_o | output | 68 | Read word, held until the next READ |
| hit_o | output | 1 | Last search found a match |
| hit_idx_o | output | 4 | Index of the winning entry, 0 on a miss |
| full_o | output | 1 | All entries occupied |

## Verification
The assertions assume one command per cycle. They also assume the opcode and select are stable while cmd_valid_i is high, and that nothing is issued during reset. They take a search result as trustworthy only in the cycle right after the SEARCH, because a later WRITE may empty the entry that won. The stimulus always drives whole commands at the falling edge and drops cmd_valid_i between commands. Random search keys are taken from stored entries, with random flips applied only to their masked bits, so that hits, misses and multiple matches all occur often.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  typedef enum logic [1:0] {
    OP_READ   = 2'b00,
    OP_WRITE  = 2'b01,
    OP_SEARCH = 2'b10,
    OP_LEARN  = 2'b11
  } tcam_op_e;

  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_MASK = 1'b1;
endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
  parameter int WIDTH = 68,
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic                         wr_sel_i,
  input  logic [IDXW-1:0]              wr_addr_i,
  input  logic [WIDTH-1:0]             wr_word_i,
  input  logic                         lrn_en_i,
  input  logic [IDXW-1:0]              lrn_idx_i,
  input  logic [WIDTH-1:0]             lrn_word_i,
  output logic [DEPTH-1:0][WIDTH-1:0]  data_o,
  output logic [DEPTH-1:0][WIDTH-1:0]  mask_o
);
  import tcam_pkg::*;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic lrn_hit, wr_hit;
    assign lrn_hit = lrn_en_i && (lrn_idx_i == IDXW'(e));
    assign wr_hit  = wr_en_i && (wr_addr_i == IDXW'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        data_o[e] <= '0;
        mask_o[e] <= '0;
      end else if (lrn_hit) begin
        data_o[e] <= lrn_word_i | WIDTH'(1);
        mask_o[e] <= '0;
      end else if (wr_hit) begin
        if (wr_sel_i == SEL_DATA) data_o[e] <= wr_word_i;
        else                      mask_o[e] <= wr_word_i;
      end
    end
  end
endmodule

// File: rtl/tcam_match.sv
module tcam_match #(
  parameter int WIDTH = 68,
  parameter int DEPTH = 16
) (
  input  logic [WIDTH-1:0]             key_i,
  input  logic [DEPTH-1:0][WIDTH-1:0]  data_i,
  input  logic [DEPTH-1:0][WIDTH-1:0]  mask_i,
  output logic [DEPTH-1:0]             match_o
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    logic [WIDTH-1:0] bit_ok;
    assign bit_ok     = ~(data_i[e] ^ key_i) | mask_i[e];
    assign match_o[e] = &bit_ok;
  end
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int N = 16,
  localparam int IDXW = $clog2(N)
) (
  input  logic [N-1:0]    req_i,
  output logic            any_o,
  output logic [IDXW-1:0] idx_o
);
  assign any_o = |req_i;

  // scan downward so the lowest set request is written last
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDXW'(i);
    end
  end
endmodule

// File: rtl/tcam_core.sv
module tcam_core #(
  parameter int WIDTH = 68,
  parameter int DEPTH = 16,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic              cmd_sel_i,
  input  logic [IDXW-1:0]   addr_i,
  input  logic [WIDTH-1:0]  dq_i,
  output logic              rd_valid_o,
  output logic [WIDTH-1:0]  rd_data_o,
  output logic              hit_o,
  output logic [IDXW-1:0]   hit_idx_o,
  output logic              full_o
);
  import tcam_pkg::*;

  logic is_rd, is_wr, is_srch, is_lrn, lrn_go;
  logic [WIDTH-1:0] key;
  logic [DEPTH-1:0][WIDTH-1:0] data_q, mask_q, mask_cmp;
  logic [DEPTH-1:0] valid_vec, free_vec, match_vec;
  logic free_any, hit_any;
  logic [IDXW-1:0] free_idx, hit_idx;

  assign is_rd   = cmd_valid_i && (cmd_op_i == OP_READ);
  assign is_wr   = cmd_valid_i && (cmd_op_i == OP_WRITE);
  assign is_srch = cmd_valid_i && (cmd_op_i == OP_SEARCH);
  assign is_lrn  = cmd_valid_i && (cmd_op_i == OP_LEARN);
  assign lrn_go  = is_lrn && free_any;

  // bit 0 of the key is forced, and bit 0 of the mask is ignored, so only occupied entries match
  assign key = {dq_i[WIDTH-1:1], 1'b1};

  for (genvar e = 0; e < DEPTH; e++) begin : g_vec
    assign valid_vec[e] = data_q[e][0];
    assign free_vec[e]  = ~data_q[e][0];
    assign mask_cmp[e]  = {mask_q[e][WIDTH-1:1], 1'b0};
  end

  tcam_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (is_wr),
    .wr_sel_i   (cmd_sel_i),
    .wr_addr_i  (addr_i),
    .wr_word_i  (dq_i),
    .lrn_en_i   (lrn_go),
    .lrn_idx_i  (free_idx),
    .lrn_word_i (key),
    .data_o     (data_q),
    .mask_o     (mask_q)
  );

  tcam_match #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_match (
    .key_i   (key),
    .data_i  (data_q),
    .mask_i  (mask_cmp),
    .match_o (match_vec)
  );

  tcam_prio_enc #(.N(DEPTH)) u_hit_pe (
    .req_i (match_vec),
    .any_o (hit_any),
    .idx_o (hit_idx)
  );

  tcam_prio_enc #(.N(DEPTH)) u_free_pe (
    .req_i (free_vec),
    .any_o (free_any),
    .idx_o (free_idx)
  );

  assign full_o = ~free_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o     <= 1'b0;
      hit_idx_o <= '0;
    end else if (is_srch) begin
      hit_o     <= hit_any;
      hit_idx_o <= hit_any ? hit_idx : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= is_rd;
      if (is_rd) rd_data_o <= (cmd_sel_i == SEL_MASK) ? mask_q[addr_i] : data_q[addr_i];
    end
  end
endmodule

// File: rtl/tcam_core_chk.sv
module tcam_core_chk #(
  parameter int DEPTH = 16,
  parameter int IDXW  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [1:0]       cmd_op_i,
  input logic             rd_valid_o,
  input logic             hit_o,
  input logic [IDXW-1:0]  hit_idx_o,
  input logic             full_o,
  input logic [DEPTH-1:0] valid_vec
);
  import tcam_pkg::*;

  assert_idx_zero_on_miss_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (hit_idx_o == '0));

  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> ($stable(hit_o) && $stable(hit_idx_o)));

  assert_rd_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_READ) |=> rd_valid_o);

  assert_rd_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_op_i == OP_READ) |=> !rd_valid_o);

  assert_hit_occupied_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_SEARCH) |=> (!hit_o || valid_vec[hit_idx_o]));

  assert_learn_adds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_LEARN && !full_o)
      |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

  assert_learn_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == OP_LEARN && full_o) |=> $stable(valid_vec));
endmodule

bind tcam_core tcam_core_chk #(.DEPTH(DEPTH), .IDXW(IDXW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .rd_valid_o  (rd_valid_o),
  .hit_o       (hit_o),
  .hit_idx_o   (hit_idx_o),
  .full_o      (full_o),
  .valid_vec   (valid_vec)
);

// File: tb/tcam_core_tb_top.sv
`timescale 1ns/1ps
module tcam_core_tb_top;
  localparam int W = 68;
  localparam int D = 16;
  localparam int AW = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [1:0] cmd_op_i = '0;
  logic cmd_sel_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [W-1:0] dq_i = '0;
  logic rd_valid_o, hit_o, full_o;
  logic [W-1:0] rd_data_o;
  logic [AW-1:0] hit_idx_o;

  always #5 clk_i = ~clk_i;

  tcam_core #(.WIDTH(W), .DEPTH(D)) dut_i (.*);

  int checks = 0;
  int failures = 0;
  logic [W-1:0] m_data [D];
  logic [W-1:0] m_mask [D];

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  function automatic logic [W-1:0] rnd68();
    logic [95:0] t;
    t = {$urandom(), $urandom(), $urandom()};
    return t[W-1:0];
  endfunction

  function automatic logic ent_match(int e, logic [W-1:0] key);
    if (!m_data[e][0]) return 1'b0;
    for (int b = 1; b < W; b++)
      if (!m_mask[e][b] && (m_data[e][b] != key[b])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int exp_idx(logic [W-1:0] key);
    for (int e = 0; e < D; e++) if (ent_match(e, key)) return e;
    return -1;
  endfunction

  function automatic logic m_full();
    for (int e = 0; e < D; e++) if (!m_data[e][0]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic cmd(logic [1:0] op, logic sel, logic [AW-1:0] a, logic [W-1:0] w);
    cmd_valid_i = 1'b1; cmd_op_i = op; cmd_sel_i = sel; addr_i = a; dq_i = w;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic wr(logic sel, int a, logic [W-1:0] w);
    cmd(2'b01, sel, AW'(a), w);
    if (sel) m_mask[a] = w; else m_data[a] = w;
  endtask

  task automatic rd(logic sel, int a, string req);
    cmd(2'b00, sel, AW'(a), '0);
    check(req, W'(rd_valid_o), W'(1));
    check(req, rd_data_o, sel ? m_mask[a] : m_data[a]);
  endtask

  task automatic srch(logic [W-1:0] key, string req);
    int ei;
    ei = exp_idx(key);
    cmd(2'b10, 1'b0, '0, key);
    check(req, W'(hit_o), W'(ei >= 0));
    check(req, W'(hit_idx_o), (ei >= 0) ? W'(ei) : W'(0));
  endtask

  task automatic lrn(logic [W-1:0] key, string req);
    if (!m_full()) begin
      for (int e = 0; e < D; e++) begin
        if (!m_data[e][0]) begin
          m_data[e] = key | W'(1);
          m_mask[e] = '0;
          break;
        end
      end
    end
    cmd(2'b11, 1'b0, '0, key);
    check(req, W'(full_o), W'(m_full()));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] k3, k;
    logic ph, pi;
    void'($urandom(32'd1234));
    for (int e = 0; e < D; e++) begin m_data[e] = '0; m_mask[e] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    check("R1", W'(hit_o), W'(0));
    check("R1", W'(hit_idx_o), W'(0));
    check("R1", W'(rd_valid_o), W'(0));
    check("R1", W'(full_o), W'(0));
    rd(1'b0, 5, "R1");
    rd(1'b1, 9, "R1");

    // R2 write/read both words
    k3 = rnd68() | W'(1);
    wr(1'b0, 3, k3);
    wr(1'b1, 3, '0);
    rd(1'b0, 3, "R2");
    rd(1'b1, 3, "R2");
    @(negedge clk_i);
    check("R2", W'(rd_valid_o), W'(0));

    // R3 exact, mismatch, masked bit
    srch(k3, "R3");
    srch(k3 ^ (W'(1) << 10), "R5");
    check("R5", W'(hit_idx_o), W'(0));
    wr(1'b1, 3, W'(1) << 10);
    srch(k3 ^ (W'(1) << 10), "R3");
    srch(k3 & ~W'(1), "R3");           // key bit 0 plays no part
    // empty entry with full don't-care mask must not match
    wr(1'b1, 1, '1);
    wr(1'b0, 1, '0);
    srch(k3, "R3");
    check("R3", W'(hit_idx_o), W'(3));

    // R4 lowest wins: entry 7 matches everything
    wr(1'b0, 7, W'(1));
    wr(1'b1, 7, '1);
    srch(k3, "R4");
    check("R4", W'(hit_idx_o), W'(3));
    srch(k3 ^ (W'(1) << 20), "R4");
    check("R4", W'(hit_idx_o), W'(7));

    // R5 hold across idle cycles
    srch(k3, "R5");
    ph = hit_o; pi = hit_idx_o[0];
    repeat (3) @(negedge clk_i);
    check("R5", W'({ph, pi}), W'({hit_o, hit_idx_o[0]}));
    check("R5", W'(hit_idx_o), W'(3));

    // random mix
    for (int n = 0; n < 600; n++) begin
      int r, e;
      r = $urandom_range(0, 9);
      e = $urandom_range(0, D - 1);
      if (r <= 2) begin
        if ($urandom_range(0, 1) == 1) wr(1'b1, e, rnd68() & rnd68() & rnd68());
        else                           wr(1'b0, e, rnd68());
      end else if (r <= 4) begin
        rd(r[0], e, "R2");
      end else if (r <= 8) begin
        if ($urandom_range(0, 3) != 0) k = m_data[e] ^ (rnd68() & m_mask[e]);
        else                           k = rnd68();
        srch(k, "R4");
      end else begin
        lrn(rnd68(), "R6");
      end
      check("R7", W'(full_o), W'(m_full()));
    end

    // R6/R7: clear, then fill with LEARN
    for (int e = 0; e < D; e++) begin wr(1'b0, e, '0); wr(1'b1, e, rnd68()); end
    check("R7", W'(full_o), W'(0));
    for (int e = 0; e < D; e++) begin
      k = rnd68();
      lrn(k, "R7");
      rd(1'b0, e, "R6");
      rd(1'b1, e, "R6");
      srch(k, "R6");
    end
    check("R7", W'(full_o), W'(1));

    // R8 learn while full
    k = rnd68();
    lrn(k, "R8");
    rd(1'b0, 0, "R8");
    rd(1'b0, D - 1, "R8");
    rd(1'b1, D - 1, "R8");
    srch(k, "R8");
    check("R8", W'(full_o), W'(1));

    // R7 freeing one entry drops full
    wr(1'b0, 6, '0);
    check("R7", W'(full_o), W'(0));
    lrn(k, "R7");
    rd(1'b0, 6, "R6");

    summary();
    $finish;
  end
endmodule